// File: doc/BRIEF.md
# Two-Channel Address Break Comparator

This block sits beside a processor bus and watches every bus cycle. Each of its two channels holds a programmed break address and an 8-bit control byte. When a strobed bus cycle hits that address, it latches a sticky match flag. The flag can drive an interrupt request. The comparison can ignore up to four low-order address bits. It can be limited to cycles owned by the CPU, or opened to cycles owned by either the CPU or a data-transfer controller. It can also be limited to one kind of access: instruction fetch, data read, data write, or any data access.

Software programs the channels through a simple register port. A select code picks one of four registers, and separate write and read strobes act on it. Read data is combinational from the select code. The match flag cannot be set by software. Clearing it takes a two-step handshake: a read strobe that returns the flag as 1, then a write of 0 to the flag. A standby input returns both control bytes to zero. It leaves the address registers alone.

Top module: `addr_break_unit`

## Requirements
- R1: After synchronous reset, all four registers read 0 and both interrupt outputs are low.
- R2: Select code 0 addresses the channel A address register and code 2 the channel B address register. Both are full-width read/write, and a write to one leaves the other unchanged.
- R3: Select code 1 addresses the channel A control byte and code 3 the channel B control byte, read on the low 8 bits of the read data. Bits 6:0 are plain read/write: bit 6 is master select, bits 5:3 are mask select, bits 2:1 are access filter and bit 0 is interrupt enable.
- R4: On a clock edge where the strobe is high and the address, master and access filter all qualify, bit 7 (the match flag) is 1 after that edge. With the strobe low nothing is flagged. With mask select 0, every address bit must be equal.
- R5: Mask select n from 0 to 4 drops address bits n-1:0 from the comparison. Values 5, 6 and 7 act as 4.
- R6: Access kind input codes are 00 fetch, 01 data read and 10 data write. The access filter accepts fetch for 00, read for 01, write for 10, and read or write for 11.
- R7: With master select 0, a cycle that has the transfer-controller owner input high never matches. With master select 1, the owner input is ignored.
- R8: The match flag stays 1 until a valid clear. Writing 1 to bit 7 never sets it.
- R9: A write of 0 to bit 7 clears the flag only when a read strobe on that control byte returned the flag as 1 since the last write to it. Otherwise the flag stays 1.
- R10: If a match and a valid clear fall on the same edge, the flag remains 1.
- R11: Each channel's interrupt output equals its match flag AND its interrupt enable bit.
- R12: Standby forces both control bytes, flags included, to 0 on the next edge. Address registers keep their values.
- R13: A match, write or clear on one channel does not alter the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Clears both control bytes on the next edge |
| reg_sel | input | SEL_W (2) | Register select: {channel, control-not-address} |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the flag clear) |
| reg_wdata | input | ADDR_W (24) | Write data; control uses bits 7:0 |
| reg_rdata | output | ADDR_W (24) | Read data of the selected register |
| bus_strobe | input | 1 | Valid bus cycle this clock |
| bus_addr | input | ADDR_W (24) | Bus cycle address |
| bus_dtc | input | 1 | 1 when the transfer controller owns the cycle |
| bus_kind | input | 2 | Access kind: 00 fetch, 01 read, 10 write |
| irq | output | NUM_CH (2) | Per-channel interrupt request |

## Verification
A qualifying bus cycle and a software clear of the same channel's flag can meet on one clock edge. A standby pulse can also land on the same edge as a match. The bench arms the clear with a read strobe and then sends the zero write together with a matching strobe, which must leave the flag at 1. Random traffic lays bus cycles over register writes, reads and rare standby pulses, and a bench model applies the stated priorities to judge each flag after the edge.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int CTRL_W   = 8;
    localparam int MASK_CAP = 4;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_IDLE  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        WATCH_FETCH = 2'b00,
        WATCH_READ  = 2'b01,
        WATCH_WRITE = 2'b10,
        WATCH_DATA  = 2'b11
    } watch_e;

    // bit order is fixed by the register view: 7 flag .. 0 enable
    typedef struct packed {
        logic       hit_flag;
        logic       any_master;
        logic [2:0] mask_sel;
        watch_e     watch;
        logic       irq_en;
    } ctrl_t;

    typedef struct packed {
        logic      strobe;
        logic      from_dtc;
        acc_kind_e kind;
    } cyc_attr_t;

    function automatic logic [2:0] ignored_bits(input logic [2:0] sel);
        return (sel > 3'(MASK_CAP)) ? 3'(MASK_CAP) : sel;
    endfunction

    function automatic logic kind_matches(input watch_e w, input acc_kind_e k);
        logic ok;
        case (w)
            WATCH_FETCH: ok = (k == ACC_FETCH);
            WATCH_READ:  ok = (k == ACC_READ);
            WATCH_WRITE: ok = (k == ACC_WRITE);
            default:     ok = (k == ACC_READ) || (k == ACC_WRITE);
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/brk_match.sv
module brk_match
    import brk_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  ctrl_t              ctrl,
    input  logic [ADDR_W-1:0]  ref_addr,
    input  cyc_attr_t          attr,
    input  logic [ADDR_W-1:0]  bus_addr,
    output logic               hit
);
    logic [ADDR_W-1:0] care;
    logic [2:0]        drop_n;
    logic              addr_eq;
    logic              master_ok;
    logic              kind_ok;

    always_comb begin
        drop_n = ignored_bits(ctrl.mask_sel);
        for (int b = 0; b < ADDR_W; b++) begin
            care[b] = (b >= int'(drop_n));
        end
    end

    assign addr_eq   = (((ref_addr ^ bus_addr) & care) == '0);
    assign master_ok = ctrl.any_master | ~attr.from_dtc;
    assign kind_ok   = kind_matches(ctrl.watch, attr.kind);
    assign hit       = attr.strobe & addr_eq & master_ok & kind_ok;

    always_comb begin
        if (hit && ctrl.mask_sel == 3'd0) begin
            assert_exact_compare_R4: assert (bus_addr == ref_addr);
        end
        if (hit && !ctrl.any_master) begin
            assert_cpu_only_R7: assert (!attr.from_dtc);
        end
    end

endmodule

// File: rtl/brk_channel.sv
module brk_channel
    import brk_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              standby,
    input  logic              addr_wr,
    input  logic              ctrl_wr,
    input  logic              ctrl_rd,
    input  logic [ADDR_W-1:0] wdata,
    input  cyc_attr_t         attr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [ADDR_W-1:0] addr_q,
    output ctrl_t             ctrl_q,
    output logic              irq
);
    logic  hit;
    logic  armed;
    ctrl_t wr_view;

    assign wr_view = ctrl_t'(wdata[CTRL_W-1:0]);

    brk_match #(.ADDR_W(ADDR_W)) u_match (
        .ctrl     (ctrl_q),
        .ref_addr (addr_q),
        .attr     (attr),
        .bus_addr (bus_addr),
        .hit      (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (addr_wr) begin
            addr_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || standby) begin
            ctrl_q <= '0;
            armed  <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.any_master <= wr_view.any_master;
                ctrl_q.mask_sel   <= wr_view.mask_sel;
                ctrl_q.watch      <= wr_view.watch;
                ctrl_q.irq_en     <= wr_view.irq_en;
            end
            if (hit) begin
                ctrl_q.hit_flag <= 1'b1;
            end else if (ctrl_wr && armed && !wr_view.hit_flag) begin
                ctrl_q.hit_flag <= 1'b0;
            end
            if (ctrl_wr) begin
                armed <= 1'b0;
            end else if (ctrl_rd && ctrl_q.hit_flag) begin
                armed <= 1'b1;
            end
        end
    end

    assign irq = ctrl_q.hit_flag & ctrl_q.irq_en;

    assert_hit_sets_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (hit && !standby) |=> ctrl_q.hit_flag);
    assert_no_spurious_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.hit_flag && !hit) |=> !ctrl_q.hit_flag);
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.hit_flag && !ctrl_wr && !standby) |=> ctrl_q.hit_flag);
    assert_clear_needs_read_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.hit_flag && ctrl_wr && !armed && !standby) |=> ctrl_q.hit_flag);
    assert_match_beats_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (hit && ctrl_wr && armed && !standby) |=> ctrl_q.hit_flag);
    assert_standby_clears_R12: assert property (@(posedge clk) disable iff (rst)
        standby |=> (ctrl_q == '0));

endmodule

// File: rtl/brk_readback.sv
module brk_readback
    import brk_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1,
    parameter int SEL_W  = 2
) (
    input  logic [SEL_W-1:0]             sel,
    input  logic [NUM_CH-1:0][ADDR_W-1:0] addr_arr,
    input  ctrl_t [NUM_CH-1:0]            ctrl_arr,
    output logic [ADDR_W-1:0]             rdata
);
    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel[SEL_W-1:1] == CH_W'(c)) begin
                if (sel[0]) begin
                    rdata[CTRL_W-1:0] = ctrl_arr[c];
                end else begin
                    rdata = addr_arr[c];
                end
            end
        end
    end

endmodule

// File: rtl/addr_break_unit.sv
module addr_break_unit
    import brk_pkg::*;
#(
    parameter  int ADDR_W = 24,
    parameter  int NUM_CH = 2,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int SEL_W  = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              standby,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              bus_strobe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_dtc,
    input  logic [1:0]        bus_kind,
    output logic [NUM_CH-1:0] irq
);
    cyc_attr_t                     attr;
    logic [NUM_CH-1:0][ADDR_W-1:0] addr_arr;
    ctrl_t [NUM_CH-1:0]            ctrl_arr;
    logic [NUM_CH-1:0]             wr_strobes;

    assign attr.strobe   = bus_strobe;
    assign attr.from_dtc = bus_dtc;
    assign attr.kind     = acc_kind_e'(bus_kind);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel_me;
        assign sel_me        = (reg_sel[SEL_W-1:1] == CH_W'(c));
        assign wr_strobes[c] = reg_wr & sel_me;

        brk_channel #(.ADDR_W(ADDR_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .standby  (standby),
            .addr_wr  (reg_wr & sel_me & ~reg_sel[0]),
            .ctrl_wr  (reg_wr & sel_me &  reg_sel[0]),
            .ctrl_rd  (reg_rd & sel_me &  reg_sel[0]),
            .wdata    (reg_wdata),
            .attr     (attr),
            .bus_addr (bus_addr),
            .addr_q   (addr_arr[c]),
            .ctrl_q   (ctrl_arr[c]),
            .irq      (irq[c])
        );
    end

    brk_readback #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .SEL_W  (SEL_W)
    ) u_rb (
        .sel      (reg_sel),
        .addr_arr (addr_arr),
        .ctrl_arr (ctrl_arr),
        .rdata    (reg_rdata)
    );

    assert_one_channel_written_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_strobes));

endmodule

// File: tb/addr_break_unit_test.sv
module addr_break_unit_test;
    localparam int PERIOD = 20;
    localparam int AW     = 24;
    localparam int NCH    = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          standby = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          bus_strobe = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_dtc = 1'b0;
    logic [1:0]    bus_kind = '0;
    logic [NCH-1:0] irq;

    int nchk = 0;
    int nfail = 0;

    logic [AW-1:0] m_addr [NCH];
    logic [7:0]    m_ctrl [NCH];
    bit            m_arm  [NCH];

    always #(PERIOD/2) clk = ~clk;

    addr_break_unit uut (
        .clk(clk), .rst(rst), .standby(standby),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_strobe(bus_strobe), .bus_addr(bus_addr),
        .bus_dtc(bus_dtc), .bus_kind(bus_kind), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    function automatic bit exp_hit(int ch, logic [AW-1:0] a, bit dtc, logic [1:0] k);
        logic [7:0] c = m_ctrl[ch];
        int n = int'(c[5:3]);
        bit aok, mok, kok;
        if (n > 4) n = 4;
        aok = ((a >> n) == (m_addr[ch] >> n));
        mok = c[6] || !dtc;
        case (c[2:1])
            2'd0: kok = (k == 2'd0);
            2'd1: kok = (k == 2'd1);
            2'd2: kok = (k == 2'd2);
            default: kok = (k == 2'd1) || (k == 2'd2);
        endcase
        return aok && mok && kok;
    endfunction

    function automatic logic [NCH-1:0] exp_irq();
        logic [NCH-1:0] v;
        for (int c = 0; c < NCH; c++) v[c] = m_ctrl[c][7] & m_ctrl[c][0];
        return v;
    endfunction

    task automatic cyc(input bit stb, input logic [AW-1:0] a, input bit dtc,
                       input logic [1:0] k, input bit wr, input bit rd,
                       input logic [1:0] sel, input logic [AW-1:0] wd, input bit sb);
        bit hits [NCH];
        @(negedge clk);
        bus_strobe = stb; bus_addr = a; bus_dtc = dtc; bus_kind = k;
        reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = wd; standby = sb;
        @(posedge clk);
        #1;
        for (int c = 0; c < NCH; c++) hits[c] = stb && exp_hit(c, a, dtc, k);
        for (int c = 0; c < NCH; c++) begin
            bit selc = (int'(sel[1]) == c) && sel[0];
            bit sela = (int'(sel[1]) == c) && !sel[0];
            if (wr && sela) m_addr[c] = wd;
            if (sb) begin
                m_ctrl[c] = 8'h00;
                m_arm[c]  = 1'b0;
            end else begin
                bit f = m_ctrl[c][7];
                bit nf = hits[c] ? 1'b1 : ((wr && selc && m_arm[c] && !wd[7]) ? 1'b0 : f);
                if (wr && selc) m_ctrl[c][6:0] = wd[6:0];
                m_ctrl[c][7] = nf;
                if (wr && selc) m_arm[c] = 1'b0;
                else if (rd && selc && f) m_arm[c] = 1'b1;
            end
        end
        bus_strobe = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; standby = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [AW-1:0] d);
        cyc(0, '0, 0, 2'd0, 1, 0, sel, d, 0);
    endtask
    task automatic rd_reg(input logic [1:0] sel);
        cyc(0, '0, 0, 2'd0, 0, 1, sel, '0, 0);
    endtask
    task automatic bus(input logic [AW-1:0] a, input bit dtc, input logic [1:0] k);
        cyc(1, a, dtc, k, 0, 0, 2'd0, '0, 0);
    endtask
    task automatic clear_flag(input int ch);
        rd_reg(2'(ch * 2 + 1));
        wr_reg(2'(ch * 2 + 1), AW'({1'b0, m_ctrl[ch][6:0]}));
    endtask

    task automatic peek_all(input string req);
        reg_wr = 1'b0; reg_rd = 1'b0; bus_strobe = 1'b0;
        chk(req, "irq", 32'(irq), 32'(exp_irq()));
        for (int s = 0; s < 4; s++) begin
            reg_sel = 2'(s);
            #1;
            if (s[0]) chk(req, $sformatf("ctrl%0d", s), 32'(reg_rdata), 32'(m_ctrl[s/2]));
            else      chk(req, $sformatf("addr%0d", s), 32'(reg_rdata), 32'(m_addr[s/2]));
        end
    endtask

    function automatic logic [AW-1:0] mk(bit master, int mask, int watch, bit ie);
        logic [7:0] v = {1'b0, master, 3'(mask), 2'(watch), ie};
        return AW'(v);
    endfunction

    initial begin
        #(PERIOD * 150000);
        nfail++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
        $finish;
    end

    initial begin
        int seed;
        seed = int'($urandom(32'h5EED_0042));
        for (int c = 0; c < NCH; c++) begin
            m_addr[c] = '0; m_ctrl[c] = '0; m_arm[c] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #2 peek_all("R1");

        wr_reg(2'd0, 24'hABCDEF); wr_reg(2'd2, 24'h123456); peek_all("R2");
        wr_reg(2'd1, 24'h0000FF); peek_all("R3 R8");
        chk("R8", "flag after write 1", 32'(reg_rdata[7]), 32'd0);
        wr_reg(2'd1, mk(0, 0, 0, 1));
        bus(24'hABCDEE, 0, 2'd0); peek_all("R4");
        cyc(0, 24'hABCDEF, 0, 2'd0, 0, 0, 2'd0, '0, 0); peek_all("R4");
        bus(24'hABCDEF, 0, 2'd0); peek_all("R4 R11");
        chk("R11", "irq A", 32'(irq), 32'd1);
        wr_reg(2'd1, mk(0, 0, 0, 1)); peek_all("R9");
        chk("R9", "flag kept without read", 32'(m_ctrl[0][7]), 32'd1);
        wr_reg(2'd1, mk(0, 0, 0, 0)); peek_all("R11");
        clear_flag(0); peek_all("R9");

        wr_reg(2'd1, mk(0, 2, 0, 1));
        bus(24'hABCDEC, 0, 2'd0); peek_all("R5");
        clear_flag(0);
        bus(24'hABCDEB, 0, 2'd0); peek_all("R5");
        wr_reg(2'd1, mk(0, 7, 0, 1));
        bus(24'hABCDE0, 0, 2'd0); peek_all("R5");
        clear_flag(0);
        bus(24'hABCDDF, 0, 2'd0); peek_all("R5");

        for (int w = 0; w < 4; w++) begin
            for (int k = 0; k < 3; k++) begin
                wr_reg(2'd1, mk(0, 0, w, 1));
                bus(24'hABCDEF, 0, 2'(k)); peek_all("R6");
                clear_flag(0);
            end
        end

        wr_reg(2'd1, mk(0, 0, 1, 1));
        bus(24'hABCDEF, 1, 2'd1); peek_all("R7");
        wr_reg(2'd1, mk(1, 0, 1, 1));
        bus(24'hABCDEF, 1, 2'd1); peek_all("R7");

        rd_reg(2'd1);
        cyc(1, 24'hABCDEF, 0, 2'd1, 1, 0, 2'd1, mk(1, 0, 1, 1), 0);
        peek_all("R10");
        chk("R10", "flag held", 32'(m_ctrl[0][7]), 32'd1);

        wr_reg(2'd3, mk(0, 0, 2, 1));
        bus(24'h123456, 0, 2'd2); peek_all("R13");
        clear_flag(1); peek_all("R13");

        cyc(0, '0, 0, 2'd0, 0, 0, 2'd0, '0, 1); peek_all("R12");

        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom % 100);
            int ch = int'($urandom % 2);
            bit stb = ($urandom % 3) != 0;
            bit dtc = $urandom % 2;
            logic [1:0] k = 2'($urandom % 3);
            logic [AW-1:0] a = (($urandom % 4) == 0) ? AW'($urandom)
                                                     : (m_addr[ch] ^ AW'($urandom % 32));
            logic [1:0] sa = 2'(ch * 2);
            logic [1:0] sc = 2'(ch * 2 + 1);
            if (r < 6)       cyc(stb, a, dtc, k, 1, 0, sa, AW'($urandom), 0);
            else if (r < 18) cyc(stb, a, dtc, k, 1, 0, sc, AW'($urandom), 0);
            else if (r < 32) cyc(stb, a, dtc, k, 0, 1, sc, '0, 0);
            else if (r < 33) cyc(stb, a, dtc, k, 0, 0, sa, '0, 1);
            else if (r < 42) cyc(stb, a, dtc, k, 1, 0, sc, AW'({1'b0, m_ctrl[ch][6:0]}), 0);
            else             cyc(stb, a, dtc, k, 0, 0, sa, '0, 0);
            if (i % 4 == 0) peek_all("R13 random");
            else chk("R11", "irq random", 32'(irq), 32'(exp_irq()));
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule